// File: doc/BRIEF.md
# Bidirectional TDM Serial Port Controller

This block is the serial side of a time-slot switch. It runs on the 2.048 MHz bit clock. A 125 us frame holds 32 channels of 8 bits, and each channel is sent most significant bit first. An active-low frame pulse, sampled on a rising edge, aligns the frame. Each serial lane has a shift register. The block moves received channel bytes into a banked data memory, one bank per lane. For every channel it asks the connection-memory side for the next channel's outgoing bytes and per-lane control bits, one channel time ahead. It also forms the memory address for CPU accesses, using a small page register together with the low CPU address bits.

The block has two port modes. In the balanced mode, eight lanes each own one input pin and one output pin. A per-channel direction bit can move the outgoing byte onto the input pin, and in that case the block captures the data on the output pin instead. In the add/drop mode, all sixteen pins are bidirectional and each lane owns one pin. A lane drives its pin only when both its direction bit and its output-enable bit are set. Every channel of every lane is written into the data memory in this mode, so a byte the block drives is read back into memory. The mode must be settled before the connection memory is programmed, because the address layout depends on it. In this block the mode is expected to change only while reset is held.

Pins are modelled as separate in, out and enable vectors. The surrounding pad logic resolves them.

Top module: `tdm_port_ctrl`

## Requirements
- R1: After reset and before the first low frame pulse, no pin enable is asserted and no data-memory write is issued.
- R2: A low frame pulse sampled on a rising edge makes the following bit slot bit 7 of channel 0. During the last slot before a frame starts, `fetch_ch` reads 0. Otherwise it reads the index of the channel after the current one. The byte and control bits presented for `fetch_ch` go out in that channel, most significant bit first.
- R3: In balanced mode (`mode_add`=0), a lane whose direction bit is 1 drives its byte on `sto_out[p]` with `sto_oe[p]`=1 and `sti_oe[p]`=0. The byte it stores comes from `sti_in[p]`.
- R4: In balanced mode, a lane whose direction bit is 0 drives its byte on `sti_out[p]` with `sti_oe[p]`=1 and `sto_oe[p]`=0. The byte it stores comes from `sto_in[p]`. The output-enable bit has no effect in this mode.
- R5: In add/drop mode (`mode_add`=1), lane k<8 uses pin `sti[k]` and lane k>=8 uses pin `sto[k-8]`. The pin is enabled only when both the direction bit and the output-enable bit of that lane are 1.
- R6: In add/drop mode, all 16 lanes store the byte seen at their pin in every channel. A lane the block drives therefore stores its own output byte.
- R7: A received byte is presented as a one-cycle write in the slot that follows its last bit. `dm_wr_ch` carries the channel, and bit k of `dm_wr_en` marks bank k (address {k, channel}). In balanced mode only banks 0 to 7 are written.
- R8: In balanced mode the CPU address is {0, page[0], cpu_addr[6:0]}. In add/drop mode it is {page[1:0], cpu_addr[6:0]}. The page register loads on a rising edge with `cpu_page_wr` high.
- R9: A CPU request whose address matches a write presented in the same cycle raises `cpu_stall` for that cycle only. A request to any other address does not stall.
- R10: Reset clears the page register, all pin enables, all writes and the stall output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2.048 MHz bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_add | input | 1 | 0 balanced, 1 add/drop |
| fp_n | input | 1 | Active-low frame pulse |
| fetch_ch | output | 5 | Channel whose outgoing data is requested |
| tx_bytes | input | 128 | Outgoing byte per lane for `fetch_ch`, lane k at bits [8k+7:8k] |
| tx_dc | input | 16 | Direction bit per lane for `fetch_ch` |
| tx_oe | input | 16 | Output-enable bit per lane for `fetch_ch` |
| sti_in | input | 8 | Resolved level on the input-side pins |
| sti_out | output | 8 | Drive value for the input-side pins |
| sti_oe | output | 8 | Drive enable for the input-side pins |
| sto_in | input | 8 | Resolved level on the output-side pins |
| sto_out | output | 8 | Drive value for the output-side pins |
| sto_oe | output | 8 | Drive enable for the output-side pins |
| dm_wr_en | output | 16 | Per-bank data-memory write strobe |
| dm_wr_ch | output | 5 | Channel being written |
| dm_wr_data | output | 128 | Byte per bank, bank k at bits [8k+7:8k] |
| cpu_page_wr | input | 1 | Load the page register |
| cpu_page_val | input | 2 | New page register value |
| cpu_req | input | 1 | CPU memory access request |
| cpu_addr | input | 7 | Low CPU address bits |
| cpu_mem_addr | output | 9 | Formed memory address |
| cpu_stall | output | 1 | Hold the CPU access one cycle |

## Verification
A slot counter out of step shows up within one bit slot. Pin bits stop matching the byte expected for the current channel, and a write strobe lands in a slot that is not a channel boundary. A stale direction or enable latch shows up as a wrong pin enable in the first slot of the affected channel. A wrong capture source shows up as a corrupted byte in the write that follows that channel's eighth bit. Address-forming faults show up at once on `cpu_mem_addr`, and a faulty stall comparator shows up in the slot that carries the matching write.

// File: rtl/tdm_port_pkg.sv
package tdm_port_pkg;
    typedef enum logic {
        MODE_BAL = 1'b0,
        MODE_ADD = 1'b1
    } port_mode_e;
endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer #(
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fp_n,
    output logic [SLOT_W-1:0] slot,
    output logic              synced
);
    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic              synced;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!fp_n) begin
            tmr_d.slot   = '0;
            tmr_d.synced = 1'b1;
        end else begin
            tmr_d.slot = tmr_q.slot + SLOT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign slot   = tmr_q.slot;
    assign synced = tmr_q.synced;
endmodule

// File: rtl/tdm_lane.sv
module tdm_lane #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] tx_byte,
    input  logic         dc_in,
    input  logic         oe_in,
    input  logic         rx_bit,
    output logic         tx_bit,
    output logic         dc,
    output logic         oe,
    output logic [W-1:0] rx_byte
);
    typedef struct packed {
        logic [W-1:0] tx_sh;
        logic [W-1:0] rx_sh;
        logic         dc;
        logic         oe;
    } lane_t;

    lane_t ln_d, ln_q;

    always_comb begin
        ln_d       = ln_q;
        ln_d.rx_sh = {ln_q.rx_sh[W-2:0], rx_bit};
        if (load) begin
            ln_d.tx_sh = tx_byte;
            ln_d.dc    = dc_in;
            ln_d.oe    = oe_in;
        end else begin
            ln_d.tx_sh = {ln_q.tx_sh[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ln_q <= '0;
        else        ln_q <= ln_d;
    end

    assign tx_bit  = ln_q.tx_sh[W-1];
    assign dc      = ln_q.dc;
    assign oe      = ln_q.oe;
    assign rx_byte = {ln_q.rx_sh[W-2:0], rx_bit};
endmodule

// File: rtl/tdm_cpu_map.sv
module tdm_cpu_map #(
    parameter int CPU_AW = 7,
    parameter int AW     = 9,
    parameter int CW     = 5,
    parameter int N_LANE = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  tdm_port_pkg::port_mode_e mode,
    input  logic                 page_wr,
    input  logic [AW-CPU_AW-1:0] page_val,
    input  logic                 req,
    input  logic [CPU_AW-1:0]    addr_lo,
    input  logic [N_LANE-1:0]    wr_en,
    input  logic [CW-1:0]        wr_ch,
    output logic [AW-1:0]        full_addr,
    output logic                 stall
);
    import tdm_port_pkg::*;
    localparam int PG_W = AW - CPU_AW;

    typedef struct packed {
        logic [PG_W-1:0] page;
    } pg_t;

    pg_t pg_d, pg_q;
    logic [AW-CW-1:0] bank;

    always_comb begin
        pg_d = pg_q;
        if (page_wr) pg_d.page = page_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pg_q <= '0;
        else        pg_q <= pg_d;
    end

    always_comb begin
        if (mode == MODE_BAL) full_addr = AW'({pg_q.page[0], addr_lo});
        else                  full_addr = {pg_q.page, addr_lo};
        bank  = full_addr[AW-1:CW];
        stall = req && wr_en[bank] && (wr_ch == full_addr[CW-1:0]);
    end
endmodule

// File: rtl/tdm_port_ctrl.sv
module tdm_port_ctrl #(
    parameter int N_PIN   = 8,
    parameter int N_CH    = 32,
    parameter int CH_BITS = 8,
    parameter int CPU_AW  = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       mode_add,
    input  logic                       fp_n,
    output logic [$clog2(N_CH)-1:0]    fetch_ch,
    input  logic [2*N_PIN*CH_BITS-1:0] tx_bytes,
    input  logic [2*N_PIN-1:0]         tx_dc,
    input  logic [2*N_PIN-1:0]         tx_oe,
    input  logic [N_PIN-1:0]           sti_in,
    output logic [N_PIN-1:0]           sti_out,
    output logic [N_PIN-1:0]           sti_oe,
    input  logic [N_PIN-1:0]           sto_in,
    output logic [N_PIN-1:0]           sto_out,
    output logic [N_PIN-1:0]           sto_oe,
    output logic [2*N_PIN-1:0]         dm_wr_en,
    output logic [$clog2(N_CH)-1:0]    dm_wr_ch,
    output logic [2*N_PIN*CH_BITS-1:0] dm_wr_data,
    input  logic                       cpu_page_wr,
    input  logic [$clog2(2*N_PIN)+$clog2(N_CH)-CPU_AW-1:0] cpu_page_val,
    input  logic                       cpu_req,
    input  logic [CPU_AW-1:0]          cpu_addr,
    output logic [$clog2(2*N_PIN)+$clog2(N_CH)-1:0] cpu_mem_addr,
    output logic                       cpu_stall
);
    import tdm_port_pkg::*;

    localparam int N_LANE = 2 * N_PIN;
    localparam int CW     = $clog2(N_CH);
    localparam int BW     = $clog2(CH_BITS);
    localparam int SLOT_W = CW + BW;
    localparam int AW     = $clog2(N_LANE) + CW;

    port_mode_e mode;
    assign mode = port_mode_e'(mode_add);

    logic [SLOT_W-1:0] slot;
    logic              synced;
    logic              ch_end;
    logic              load;

    tdm_frame_timer #(.SLOT_W(SLOT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .fp_n(fp_n), .slot(slot), .synced(synced)
    );

    assign ch_end   = (slot[BW-1:0] == BW'(CH_BITS - 1));
    assign load     = !fp_n || ch_end;
    assign fetch_ch = fp_n ? (slot[SLOT_W-1:BW] + CW'(1)) : '0;

    logic [N_LANE-1:0]         tx_bit, ln_dc, ln_oe, rx_bit;
    logic [N_LANE*CH_BITS-1:0] rx_bytes;

    for (genvar k = 0; k < N_LANE; k++) begin : g_lane
        tdm_lane #(.W(CH_BITS)) u_lane (
            .clk(clk), .rst_n(rst_n), .load(load),
            .tx_byte(tx_bytes[k*CH_BITS +: CH_BITS]),
            .dc_in(tx_dc[k]), .oe_in(tx_oe[k]), .rx_bit(rx_bit[k]),
            .tx_bit(tx_bit[k]), .dc(ln_dc[k]), .oe(ln_oe[k]),
            .rx_byte(rx_bytes[k*CH_BITS +: CH_BITS])
        );
    end

    // pin steering and capture source per mode
    always_comb begin
        sti_out = '0;
        sto_out = '0;
        sti_oe  = '0;
        sto_oe  = '0;
        rx_bit  = '0;
        for (int p = 0; p < N_PIN; p++) begin
            if (mode == MODE_BAL) begin
                sti_out[p] = tx_bit[p];
                sto_out[p] = tx_bit[p];
                sti_oe[p]  = synced & ~ln_dc[p];
                sto_oe[p]  = synced & ln_dc[p];
                rx_bit[p]  = ln_dc[p] ? sti_in[p] : sto_in[p];
            end else begin
                sti_out[p]       = tx_bit[p];
                sto_out[p]       = tx_bit[p+N_PIN];
                sti_oe[p]        = synced & ln_dc[p] & ln_oe[p];
                sto_oe[p]        = synced & ln_dc[p+N_PIN] & ln_oe[p+N_PIN];
                rx_bit[p]        = sti_in[p];
                rx_bit[p+N_PIN]  = sto_in[p];
            end
        end
    end

    typedef struct packed {
        logic [N_LANE-1:0]         en;
        logic [CW-1:0]             ch;
        logic [N_LANE*CH_BITS-1:0] data;
    } wr_t;

    wr_t wr_d, wr_q;

    always_comb begin
        wr_d    = wr_q;
        wr_d.en = '0;
        if (synced && ch_end) begin
            for (int k = 0; k < N_LANE; k++)
                wr_d.en[k] = (mode == MODE_ADD) || (k < N_PIN);
            wr_d.ch   = slot[SLOT_W-1:BW];
            wr_d.data = rx_bytes;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wr_q <= '0;
        else        wr_q <= wr_d;
    end

    assign dm_wr_en   = wr_q.en;
    assign dm_wr_ch   = wr_q.ch;
    assign dm_wr_data = wr_q.data;

    tdm_cpu_map #(.CPU_AW(CPU_AW), .AW(AW), .CW(CW), .N_LANE(N_LANE)) u_cpu (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .page_wr(cpu_page_wr), .page_val(cpu_page_val),
        .req(cpu_req), .addr_lo(cpu_addr),
        .wr_en(wr_q.en), .wr_ch(wr_q.ch),
        .full_addr(cpu_mem_addr), .stall(cpu_stall)
    );
endmodule

// File: rtl/tdm_port_ctrl_chk.sv
module tdm_port_ctrl_chk #(
    parameter int N_PIN = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mode_add,
    input logic               synced,
    input logic [N_PIN-1:0]   sti_oe,
    input logic [N_PIN-1:0]   sto_oe,
    input logic [2*N_PIN-1:0] dm_wr_en,
    input logic               cpu_stall
);
    // R1: silent until aligned to a frame
    p_quiet_unsynced_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !synced |-> (sti_oe == '0 && sto_oe == '0 && dm_wr_en == '0));

    // R4: balanced mode never enables both pins of one lane
    p_one_pin_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_add |-> ((sti_oe & sto_oe) == '0));

    // R7: balanced mode leaves the upper banks untouched
    p_bal_banks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_add |-> (dm_wr_en[2*N_PIN-1:N_PIN] == '0));

    // R7: write strobe lasts one slot
    p_wr_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dm_wr_en != '0) |=> (dm_wr_en == '0));

    // R9: stall never lasts two cycles
    p_stall_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |=> !cpu_stall);
endmodule

bind tdm_port_ctrl tdm_port_ctrl_chk #(.N_PIN(N_PIN)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_add(mode_add), .synced(synced),
    .sti_oe(sti_oe), .sto_oe(sto_oe), .dm_wr_en(dm_wr_en), .cpu_stall(cpu_stall)
);

// File: tb/tdm_port_ctrl_test.sv
module tdm_port_ctrl_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_add = 1'b0;
    logic         fp_n = 1'b1;
    logic [4:0]   fetch_ch;
    logic [127:0] tx_bytes;
    logic [15:0]  tx_dc, tx_oe;
    logic [7:0]   sti_in, sti_out, sti_oe, sto_in, sto_out, sto_oe;
    logic [7:0]   ext_sti = '0, ext_sto = '0;
    logic [15:0]  dm_wr_en;
    logic [4:0]   dm_wr_ch;
    logic [127:0] dm_wr_data;
    logic         cpu_page_wr = 1'b0;
    logic [1:0]   cpu_page_val = '0;
    logic         cpu_req = 1'b0;
    logic [6:0]   cpu_addr = '0;
    logic [8:0]   cpu_mem_addr;
    logic         cpu_stall;

    int checks = 0, errors = 0;
    int seed = 17;
    bit done = 1'b0;

    typedef struct packed {
        logic [4:0]   ch;
        logic [15:0]  mask;
        logic [127:0] data;
    } wr_item_t;
    wr_item_t exp_q[$];

    always #5 clk = ~clk;

    tdm_port_ctrl uut (
        .clk(clk), .rst_n(rst_n), .mode_add(mode_add), .fp_n(fp_n),
        .fetch_ch(fetch_ch), .tx_bytes(tx_bytes), .tx_dc(tx_dc), .tx_oe(tx_oe),
        .sti_in(sti_in), .sti_out(sti_out), .sti_oe(sti_oe),
        .sto_in(sto_in), .sto_out(sto_out), .sto_oe(sto_oe),
        .dm_wr_en(dm_wr_en), .dm_wr_ch(dm_wr_ch), .dm_wr_data(dm_wr_data),
        .cpu_page_wr(cpu_page_wr), .cpu_page_val(cpu_page_val),
        .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .cpu_mem_addr(cpu_mem_addr), .cpu_stall(cpu_stall)
    );

    assign sti_in = (sti_oe & sti_out) | (~sti_oe & ext_sti);
    assign sto_in = (sto_oe & sto_out) | (~sto_oe & ext_sto);

    function automatic logic [7:0] tx_of(int ch, int k);
        return 8'((ch * 8 + k * 29 + 90) ^ seed);
    endfunction
    function automatic logic [7:0] ext_of(int ch, int idx);
        return 8'((ch * 13 + idx * 7 + seed) ^ 8'hC3);
    endfunction
    function automatic logic dc_of(int ch, int k);
        return ((ch + k) % 3) != 0;
    endfunction
    function automatic logic oe_of(int ch, int k);
        return ((ch + 2 * k) % 4) != 1;
    endfunction

    // connection-memory model answering the lookahead request
    always_comb begin
        for (int k = 0; k < 16; k++) begin
            tx_bytes[k*8 +: 8] = tx_of(int'(fetch_ch), k);
            tx_dc[k]           = dc_of(int'(fetch_ch), k);
            tx_oe[k]           = oe_of(int'(fetch_ch), k);
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && dm_wr_en != '0) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 unexpected write", 128'(dm_wr_en), 128'(0));
            end else begin
                wr_item_t it;
                it = exp_q.pop_front();
                chk(dm_wr_en == it.mask, "R7 write bank mask", 128'(dm_wr_en), 128'(it.mask));
                chk(dm_wr_ch == it.ch, "R7 write channel", 128'(dm_wr_ch), 128'(it.ch));
                for (int k = 0; k < 16; k++)
                    if (it.mask[k])
                        chk(dm_wr_data[k*8 +: 8] == it.data[k*8 +: 8],
                            $sformatf("R6 R3 R4 stored byte bank %0d", k),
                            128'(dm_wr_data[k*8 +: 8]), 128'(it.data[k*8 +: 8]));
            end
        end
    end

    task automatic do_reset(input logic m);
        rst_n = 1'b0;
        mode_add = m;
        fp_n = 1'b1;
        cpu_req = 1'b0;
        exp_q.delete();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic set_page(input logic [1:0] pg);
        @(negedge clk);
        cpu_page_wr = 1'b1;
        cpu_page_val = pg;
        @(negedge clk);
        cpu_page_wr = 1'b0;
    endtask

    task automatic run_frames(input int nfr, input logic [8:0] st_addr, input int st_slot);
        @(negedge clk);
        fp_n = 1'b0;
        for (int f = 0; f < nfr; f++) begin
            for (int t = 0; t < 256; t++) begin
                int c, b;
                logic [7:0] e_sti_oe, e_sto_oe, e_sti_v, e_sto_v;
                @(negedge clk);
                c = t / 8;
                b = t % 8;
                fp_n = (t == 255 && f < nfr - 1) ? 1'b0 : 1'b1;
                for (int p = 0; p < 8; p++) begin
                    ext_sti[p] = ext_of(c, p)[7-b];
                    ext_sto[p] = ext_of(c, p + 8)[7-b];
                end
                cpu_req  = (f == 0) && (t == st_slot || t == st_slot + 1 || t == st_slot + 8);
                cpu_addr = st_addr[6:0];
                #1;
                if (b == 0)
                    chk(fetch_ch == 5'((c + 1) % 32), "R2 lookahead channel", 128'(fetch_ch), 128'((c + 1) % 32));
                for (int p = 0; p < 8; p++) begin
                    if (!mode_add) begin
                        e_sti_oe[p] = !dc_of(c, p);
                        e_sto_oe[p] = dc_of(c, p);
                        e_sti_v[p]  = tx_of(c, p)[7-b];
                        e_sto_v[p]  = tx_of(c, p)[7-b];
                    end else begin
                        e_sti_oe[p] = dc_of(c, p) & oe_of(c, p);
                        e_sto_oe[p] = dc_of(c, p + 8) & oe_of(c, p + 8);
                        e_sti_v[p]  = tx_of(c, p)[7-b];
                        e_sto_v[p]  = tx_of(c, p + 8)[7-b];
                    end
                end
                if (!mode_add) begin
                    chk({sti_oe, sto_oe} == {e_sti_oe, e_sto_oe}, "R3 R4 balanced pin enables",
                        128'({sti_oe, sto_oe}), 128'({e_sti_oe, e_sto_oe}));
                    chk({sti_out & e_sti_oe, sto_out & e_sto_oe} == {e_sti_v & e_sti_oe, e_sto_v & e_sto_oe},
                        "R2 R3 R4 balanced msb-first bits",
                        128'({sti_out & e_sti_oe, sto_out & e_sto_oe}), 128'({e_sti_v & e_sti_oe, e_sto_v & e_sto_oe}));
                end else begin
                    chk({sti_oe, sto_oe} == {e_sti_oe, e_sto_oe}, "R5 add/drop pin enables",
                        128'({sti_oe, sto_oe}), 128'({e_sti_oe, e_sto_oe}));
                    chk({sti_out & e_sti_oe, sto_out & e_sto_oe} == {e_sti_v & e_sti_oe, e_sto_v & e_sto_oe},
                        "R2 R5 add/drop msb-first bits",
                        128'({sti_out & e_sti_oe, sto_out & e_sto_oe}), 128'({e_sti_v & e_sti_oe, e_sto_v & e_sto_oe}));
                end
                if (f == 0 && t == st_slot)
                    chk(cpu_stall == 1'b1, "R9 stall on matching write", 128'(cpu_stall), 128'(1));
                if (f == 0 && (t == st_slot + 1 || t == st_slot + 8))
                    chk(cpu_stall == 1'b0, "R9 no stall otherwise", 128'(cpu_stall), 128'(0));
                if (b == 7) begin
                    wr_item_t it;
                    it.ch = 5'(c);
                    it.mask = mode_add ? 16'hFFFF : 16'h00FF;
                    it.data = '0;
                    for (int k = 0; k < 16; k++) begin
                        if (!mode_add) begin
                            if (k < 8) it.data[k*8 +: 8] = dc_of(c, k) ? ext_of(c, k) : ext_of(c, k + 8);
                        end else begin
                            it.data[k*8 +: 8] = (dc_of(c, k) && oe_of(c, k)) ? tx_of(c, k) : ext_of(c, k);
                        end
                    end
                    exp_q.push_back(it);
                end
            end
        end
        @(negedge clk);
        cpu_req = 1'b0;
        fp_n = 1'b1;
        @(negedge clk);
        chk(exp_q.size() == 0, "R7 all channel writes seen", 128'(exp_q.size()), 128'(0));
    endtask

    initial begin
        // R10 reset state
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk({sti_oe, sto_oe} == '0, "R10 pins idle in reset", 128'({sti_oe, sto_oe}), 128'(0));
        chk(dm_wr_en == '0, "R10 no write in reset", 128'(dm_wr_en), 128'(0));
        chk(cpu_stall == 1'b0, "R10 no stall in reset", 128'(cpu_stall), 128'(0));
        chk(cpu_mem_addr == '0, "R10 page cleared", 128'(cpu_mem_addr), 128'(0));

        // balanced run
        do_reset(1'b0);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            chk({sti_oe, sto_oe} == '0 && dm_wr_en == '0, "R1 quiet before frame pulse",
                128'({dm_wr_en, sti_oe, sto_oe}), 128'(0));
        end
        cpu_addr = 7'h55;
        set_page(2'b11);
        #1;
        chk(cpu_mem_addr == 9'h0D5, "R8 balanced address", 128'(cpu_mem_addr), 128'(9'h0D5));
        set_page(2'b00);
        run_frames(2, 9'd100, 40);   // bank 3, channel 4

        // add/drop run
        seed = 201;
        do_reset(1'b1);
        cpu_addr = 7'h55;
        set_page(2'b10);
        #1;
        chk(cpu_mem_addr == 9'h155, "R8 add/drop address", 128'(cpu_mem_addr), 128'(9'h155));
        set_page(2'b11);
        run_frames(2, 9'd393, 80);   // bank 12, channel 9
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule